// File: doc/BRIEF.md
# Ethernet Transmit Frame Padder

The block turns a frame that software has placed in a transmit byte buffer into a byte stream for a MAC transmitter. The buffer holds only the header (destination address, source address, type/length) and the payload. The frame check sequence is never stored there. Software gives an end pointer that marks the last real payload byte, and then pulses a start strobe. The block reads the buffer from offset 0 up to the end pointer. When the payload is shorter than the minimum of 46 bytes, it adds zero bytes. It then appends the 32-bit CRC and sends it least significant byte first.

The header takes buffer offsets 0 to 13, so the payload length is the end pointer minus 13. The buffer read port is combinational: the address `buf_rd_addr_o` equals the index of the byte now offered, and `buf_rd_data_i` must return that byte in the same cycle. The output is a valid/ready byte stream with a last flag on the final FCS byte. A one-cycle done pulse follows the acceptance of that byte.

The control is a five-state machine:
- **IDLE**: waits for the strobe. The transition *launch* (start seen) clears the byte counter and the CRC, latches the end pointer, and enters **DATA**.
- **DATA**: streams buffer bytes. On acceptance of the byte at the end pointer, the block takes one of two transitions:
  - *data_to_pad*: taken when fewer than 60 bytes have been sent. It enters **PAD**.
  - *data_to_fcs*: taken otherwise. It enters **FCS**.
- **PAD**: emits zero bytes. The transition *pad_to_fcs* fires when byte 59 is accepted.
- **FCS**: emits the four CRC bytes. The transition *fcs_to_done* follows the fourth byte.
- **DONE**: pulses done for one cycle. The transition *retire* returns the block to **IDLE**.

Top module: `eth_tx_padder`

## Requirements
- R1: While reset is held, and on the first sampled cycle after it is released, `tx_valid_o`, `tx_last_o` and `done_o` are 0.
- R2: After a start, the first bytes offered are the buffer bytes at offsets 0 up to the latched end pointer, in rising order. `buf_rd_addr_o` equals the offset of the byte being offered.
- R3: When the end pointer is below 59, zero bytes (0x00) follow the last buffer byte. The total number of bytes before the FCS is then exactly 60, which is 14 header bytes plus a 46-byte payload.
- R4: When the end pointer is 59 or more, no pad byte is added. The FCS directly follows the byte at the end pointer.
- R5: Four FCS bytes follow the header, payload and pad. They are computed as a CRC-32 with reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF, and a final complement. The CRC covers every preceding byte, and its bytes are sent least significant byte first.
- R6: `tx_last_o` is 1 only together with `tx_valid_o`, and only on the fourth FCS byte. Exactly one accepted byte per frame carries it.
- R7: While `tx_valid_o` is 1 and `tx_ready_i` is 0, the next cycle holds `tx_valid_o` high with unchanged `tx_data_o` and `tx_last_o`.
- R8: `done_o` is 1 for exactly the one cycle after the last byte is accepted. `tx_valid_o` is 0 in that cycle.
- R9: A start seen in any state other than IDLE is ignored, including in the cycle in which the last byte is accepted. Neither the frame in progress nor the latched end pointer changes, and no second frame follows.
- R10: In IDLE without a start, `tx_valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, used only in IDLE |
| eof_ptr_i | input | PTR_W | Offset of the last real payload byte, sampled with the start |
| buf_rd_addr_o | output | PTR_W | Buffer read offset |
| buf_rd_data_i | input | 8 | Buffer byte at `buf_rd_addr_o`, same cycle |
| tx_data_o | output | 8 | Output byte |
| tx_valid_o | output | 1 | Output byte valid |
| tx_ready_i | input | 1 | Sink accepts the byte |
| tx_last_o | output | 1 | Final FCS byte |
| done_o | output | 1 | One-cycle pulse after the frame ends |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is the end of the real payload and the minimum-length boundary. With an end pointer of 59, the last buffer byte is also byte 59. The machine must then skip PAD and go straight to FCS. The bench judges this by the frame length, 64 bytes, and by the absence of any zero byte before the CRC.

The second pair is a new start and the acceptance of the final FCS byte. The bench raises the strobe in exactly the cycle in which the last-flagged byte is accepted. It then checks that done still pulses once, and that the output stays idle with no second frame afterwards.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_PAD,
        ST_FCS,
        ST_DONE
    } tx_state_e;

    localparam int          FCS_BYTES     = 4;
    localparam int          FIDX_W        = $clog2(FCS_BYTES);
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

    // One byte of reflected CRC-32, processed bit 0 first.
    function automatic logic [31:0] crc32_step(input logic [31:0] c,
                                               input logic [7:0]  d);
        logic [31:0] r;
        r = c;
        for (int b = 0; b < 8; b++) begin
            if (r[0] ^ d[b])
                r = (r >> 1) ^ CRC_POLY_REFL;
            else
                r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/eth_tx_seq_fsm.sv
module eth_tx_seq_fsm
    import eth_tx_pkg::*;
#(
    parameter int PTR_W    = 11,
    parameter int HDR_LEN  = 14,
    parameter int MIN_DATA = 46
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PTR_W-1:0]  eof_ptr_i,
    input  logic              ready_i,
    output tx_state_e         state_o,
    output logic [PTR_W-1:0]  cnt_o,
    output logic [FIDX_W-1:0] fidx_o,
    output logic              accept_o,
    output logic              launch_o
);

    localparam int                MIN_FRAME = HDR_LEN + MIN_DATA;
    localparam logic [PTR_W-1:0]  PAD_END   = PTR_W'(MIN_FRAME - 1);
    localparam logic [PTR_W-1:0]  CNT_ONE   = PTR_W'(1);
    localparam logic [FIDX_W-1:0] FIDX_LAST = FIDX_W'(FCS_BYTES - 1);
    localparam logic [FIDX_W-1:0] FIDX_ONE  = FIDX_W'(1);

    tx_state_e         state_q, state_d;
    logic [PTR_W-1:0]  eof_q;
    logic [PTR_W-1:0]  cnt_q;
    logic [FIDX_W-1:0] fidx_q;
    logic              streaming;
    logic              accept;
    logic              launch;

    assign streaming = (state_q == ST_DATA) || (state_q == ST_PAD) ||
                       (state_q == ST_FCS);
    assign accept    = streaming && ready_i;
    assign launch    = (state_q == ST_IDLE) && start_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Transitions: launch, data_to_pad, data_to_fcs, pad_to_fcs,
    // fcs_to_done, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i)
                    state_d = ST_DATA;
            end
            ST_DATA: begin
                if (accept && (cnt_q == eof_q))
                    state_d = (cnt_q < PAD_END) ? ST_PAD : ST_FCS;
            end
            ST_PAD: begin
                if (accept && (cnt_q == PAD_END))
                    state_d = ST_FCS;
            end
            ST_FCS: begin
                if (accept && (fidx_q == FIDX_LAST))
                    state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Frame bookkeeping: latched end pointer, byte count, FCS index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eof_q  <= '0;
            cnt_q  <= '0;
            fidx_q <= '0;
        end else if (launch) begin
            eof_q  <= eof_ptr_i;
            cnt_q  <= '0;
            fidx_q <= '0;
        end else if (accept) begin
            if (state_q == ST_FCS)
                fidx_q <= fidx_q + FIDX_ONE;
            else
                cnt_q  <= cnt_q + CNT_ONE;
        end
    end

    // Outputs
    always_comb begin
        state_o  = state_q;
        cnt_o    = cnt_q;
        fidx_o   = fidx_q;
        accept_o = accept;
        launch_o = launch;
    end

endmodule

// File: rtl/eth_tx_crc32.sv
module eth_tx_crc32
    import eth_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr_i,
    input  logic        en_i,
    input  logic [7:0]  byte_i,
    output logic [31:0] crc_o
);

    logic [31:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc_q <= CRC_SEED;
        else if (clr_i)
            crc_q <= CRC_SEED;
        else if (en_i)
            crc_q <= crc32_step(crc_q, byte_i);
    end

    assign crc_o = crc_q;

endmodule

// File: rtl/eth_tx_out_stage.sv
module eth_tx_out_stage
    import eth_tx_pkg::*;
(
    input  tx_state_e         state_i,
    input  logic [FIDX_W-1:0] fidx_i,
    input  logic [7:0]        buf_byte_i,
    input  logic [31:0]       crc_i,
    output logic [7:0]        data_o,
    output logic              valid_o,
    output logic              last_o,
    output logic              done_o
);

    localparam logic [FIDX_W-1:0] FIDX_LAST = FIDX_W'(FCS_BYTES - 1);

    logic [31:0] fcs_word;
    assign fcs_word = ~crc_i;

    always_comb begin
        data_o  = 8'h00;
        valid_o = 1'b0;
        last_o  = 1'b0;
        done_o  = 1'b0;
        unique case (state_i)
            ST_IDLE: ;
            ST_DATA: begin
                data_o  = buf_byte_i;
                valid_o = 1'b1;
            end
            ST_PAD: begin
                data_o  = 8'h00;
                valid_o = 1'b1;
            end
            ST_FCS: begin
                data_o  = fcs_word[{fidx_i, 3'b000} +: 8];
                valid_o = 1'b1;
                last_o  = (fidx_i == FIDX_LAST);
            end
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/eth_tx_padder.sv
module eth_tx_padder
    import eth_tx_pkg::*;
#(
    parameter int PTR_W    = 11,
    parameter int HDR_LEN  = 14,
    parameter int MIN_DATA = 46
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [PTR_W-1:0] eof_ptr_i,
    output logic [PTR_W-1:0] buf_rd_addr_o,
    input  logic [7:0]       buf_rd_data_i,
    output logic [7:0]       tx_data_o,
    output logic             tx_valid_o,
    input  logic             tx_ready_i,
    output logic             tx_last_o,
    output logic             done_o
);

    tx_state_e         state;
    logic [PTR_W-1:0]  cnt;
    logic [FIDX_W-1:0] fidx;
    logic              accept;
    logic              launch;
    logic [31:0]       crc;
    logic              crc_en;

    eth_tx_seq_fsm #(
        .PTR_W    (PTR_W),
        .HDR_LEN  (HDR_LEN),
        .MIN_DATA (MIN_DATA)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .eof_ptr_i(eof_ptr_i),
        .ready_i  (tx_ready_i),
        .state_o  (state),
        .cnt_o    (cnt),
        .fidx_o   (fidx),
        .accept_o (accept),
        .launch_o (launch)
    );

    assign crc_en = accept && (state != ST_FCS);

    eth_tx_crc32 crc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (launch),
        .en_i  (crc_en),
        .byte_i(tx_data_o),
        .crc_o (crc)
    );

    eth_tx_out_stage out_i (
        .state_i   (state),
        .fidx_i    (fidx),
        .buf_byte_i(buf_rd_data_i),
        .crc_i     (crc),
        .data_o    (tx_data_o),
        .valid_o   (tx_valid_o),
        .last_o    (tx_last_o),
        .done_o    (done_o)
    );

    assign buf_rd_addr_o = cnt;

endmodule

// File: rtl/eth_tx_padder_chk.sv
module eth_tx_padder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] tx_data_o,
    input logic       tx_valid_o,
    input logic       tx_ready_i,
    input logic       tx_last_o,
    input logic       done_o
);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=>
            (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));

    assert_last_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last_o |-> tx_valid_o);

    assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && tx_ready_i && tx_last_o) |=> done_o);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !tx_valid_o);

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !tx_valid_o);

endmodule

bind eth_tx_padder eth_tx_padder_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_data_o (tx_data_o),
    .tx_valid_o(tx_valid_o),
    .tx_ready_i(tx_ready_i),
    .tx_last_o (tx_last_o),
    .done_o    (done_o)
);

// File: tb/eth_tx_padder_tb_top.sv
`timescale 1ns/1ps
module eth_tx_padder_tb_top;

    localparam int PTR_W = 11;
    localparam int DEPTH = 1 << PTR_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [PTR_W-1:0] eof_ptr = '0;
    logic [PTR_W-1:0] buf_addr;
    logic [7:0]       buf_data;
    logic [7:0]       tx_data;
    logic             tx_valid;
    logic             tx_ready = 1'b1;
    logic             tx_last;
    logic             done;

    logic [7:0] mem [0:DEPTH-1];
    logic [7:0] rx  [0:DEPTH+63];

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    assign buf_data = mem[buf_addr];

    eth_tx_padder #(.PTR_W(PTR_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .eof_ptr_i    (eof_ptr),
        .buf_rd_addr_o(buf_addr),
        .buf_rd_data_i(buf_data),
        .tx_data_o    (tx_data),
        .tx_valid_o   (tx_valid),
        .tx_ready_i   (tx_ready),
        .tx_last_o    (tx_last),
        .done_o       (done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb = r[0] ^ d[i];
            r = {1'b0, r[31:1]};
            if (fb) r = r ^ 32'hEDB88320;
        end
        return r;
    endfunction

    // inject: 0 none, 1 start with other pointer mid-frame, 2 start on last accept
    task automatic run_frame(input int eof, input bit bp, input int inject,
                             input int seed, input string tag);
        int n = 0, cyc = 0, lasts = 0, lastpos = -1, body;
        bit got_last = 0, stall = 0, addr_ok = 1, hold_ok = 1;
        logic [7:0] pdata; logic plast;
        logic [7:0] expb; logic [31:0] crc; int bad;
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'((i * 37 + seed) ^ (i >> 3));
        eof_ptr = PTR_W'(eof);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        pdata = '0; plast = 1'b0;
        while (!got_last && cyc < 5000) begin
            tx_ready = bp ? ((cyc % 3) != 0) : 1'b1;
            start = 1'b0;
            #1;
            if (stall && !(tx_valid && tx_data == pdata && tx_last == plast)) hold_ok = 0;
            if (inject == 1 && n == 20 && tx_ready && tx_valid) begin
                start = 1'b1; eof_ptr = PTR_W'(eof + 200);
            end
            if (inject == 2 && tx_valid && tx_ready && tx_last) start = 1'b1;
            if (tx_valid && tx_ready) begin
                if (n <= eof && buf_addr != PTR_W'(n)) addr_ok = 0;
                rx[n] = tx_data;
                if (tx_last) begin lasts++; lastpos = n; got_last = 1; end
                n++;
            end
            stall = tx_valid && !tx_ready;
            pdata = tx_data; plast = tx_last;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; tx_ready = 1'b1; eof_ptr = PTR_W'(eof);
        #1;
        chk(done == 1'b1 && tx_valid == 1'b0, {tag, " R8 done after last"},
            {done, tx_valid}, 2'b10);
        @(negedge clk); #1;
        chk(done == 1'b0, {tag, " R8 done one cycle"}, done, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            chk(tx_valid == 1'b0, {tag, " R9 R10 no further frame"}, tx_valid, 0);
        end
        body = (eof + 1 > 60) ? eof + 1 : 60;
        chk(n == body + 4, {tag, " R3 R4 frame length"}, n, body + 4);
        chk(lasts == 1 && lastpos == n - 1, {tag, " R6 last position"}, lastpos, n - 1);
        chk(addr_ok, {tag, " R2 read address"}, addr_ok, 1);
        chk(hold_ok, {tag, " R7 hold under backpressure"}, hold_ok, 1);
        crc = 32'hFFFFFFFF; bad = -1;
        for (int i = 0; i < body; i++) begin
            expb = (i <= eof) ? mem[i] : 8'h00;
            crc = ref_crc(crc, expb);
            if (bad < 0 && rx[i] != expb) bad = i;
        end
        chk(bad < 0, {tag, " R2 R3 R4 body bytes"}, bad, -1);
        crc = ~crc;
        chk({rx[body+3], rx[body+2], rx[body+1], rx[body]} == crc,
            {tag, " R5 FCS"}, {rx[body+3], rx[body+2], rx[body+1], rx[body]}, crc);
    endtask

    task automatic test_reset();
        #1;
        chk(!tx_valid && !tx_last && !done, "R1 during reset", {tx_valid, tx_last, done}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!tx_valid && !tx_last && !done, "R1 after release", {tx_valid, tx_last, done}, 0);
        repeat (4) @(negedge clk);
        #1;
        chk(!tx_valid, "R10 idle without start", tx_valid, 0);
    endtask

    task automatic test_empty_payload();   run_frame(13, 0, 0, 5,  "empty R3");   endtask
    task automatic test_short_payload();   run_frame(30, 1, 0, 11, "short R3");   endtask
    task automatic test_exact_minimum();   run_frame(59, 0, 0, 23, "exact R4");   endtask
    task automatic test_long_payload();    run_frame(300, 1, 0, 41, "long R4");   endtask
    task automatic test_start_mid_frame(); run_frame(40, 0, 1, 77, "mid R9");     endtask
    task automatic test_start_on_last();   run_frame(70, 1, 2, 91, "onlast R9");  endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        test_empty_payload();
        test_short_payload();
        test_exact_minimum();
        test_long_payload();
        test_start_mid_frame();
        test_start_on_last();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule